// File: doc/BRIEF.md
# Length-Prefixed Frame Readout Port

This block holds one received frame in an internal byte buffer and hands it to an external host over a byte-wide parallel port. The host paces the port with an asynchronous, active-low read strobe. The frame is loaded through a simple internal write interface: a byte bus with a valid qualifier and an end-of-frame marker. When the frame is closed, the block waits for an inter-frame gap, counted in clock cycles, during which the transmit carrier input must stay low. It then raises a frame-available flag. Each debounced rising edge of the read strobe moves the port to the next byte. The first two bytes give the payload length, high byte first, and the stored payload follows.

The read strobe passes through a two-flop synchronizer and then a debouncer with a configurable hold count, so glitches on the host pin do not advance the port. The output enable for the bidirectional data pins comes straight from the chip-select and read-strobe pins, so the pad drivers turn on only while the host is actually reading.

Top module: `frmrd_port`

## Requirements
- R1: With `tx_carrier_i` low, `frame_avail_o` rises exactly GAP_CYC clock cycles after the clock edge that accepts the end-of-frame marker, and not earlier.
- R2: While `tx_carrier_i` is high, `frame_avail_o` does not rise. Any cycle with the carrier high restarts the gap count, so the flag rises GAP_CYC cycles after the carrier has been low again.
- R3: While `frame_avail_o` is high, `pin_data_o` moves to the next byte once for each debounced rising edge of `host_rd_n_i`, and at no other time. The first byte is present when the flag rises.
- R4: Byte 0 on the port is bits 15..8 of the 16-bit payload length, byte 1 is bits 7..0, and bytes 2 onward are the payload in write order.
- R5: `frame_avail_o` falls on the strobe rising edge that takes the last byte (byte index length+1). A zero-length frame therefore sends only the two length bytes.
- R6: `pin_oe_o` is high exactly when `host_cs_n_i` and `host_rd_n_i` are both low, with no clock delay.
- R7: A change on `host_rd_n_i` lasting fewer than DEB_CYC clock cycles does not advance the port.
- R8: `wr_ready_o` is high only while no frame is held. Writes and end markers offered while it is low are ignored, and the held frame reads out unchanged.
- R9: An end marker with `wr_valid_i` low closes the frame without adding a byte. Bytes beyond DEPTH are dropped, and the length counts only the stored bytes.
- R10: After reset, `frame_avail_o` is low and `wr_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data_i | input | 8 | Frame byte from the internal writer |
| wr_valid_i | input | 1 | `wr_data_i` holds a byte to store |
| wr_last_i | input | 1 | Closes the frame (includes the byte if `wr_valid_i` is high) |
| wr_ready_o | output | 1 | Buffer is free to take a frame |
| tx_carrier_i | input | 1 | Transmit session in progress |
| host_cs_n_i | input | 1 | Host chip select, active low |
| host_rd_n_i | input | 1 | Host read strobe, active low, asynchronous |
| frame_avail_o | output | 1 | Frame readout in progress |
| pin_data_o | output | 8 | Byte to drive onto the data pins |
| pin_oe_o | output | 1 | Output enable for the data pin drivers |

## Verification
The hardest case to reach from the ports is carrier activity in the middle of the gap, because the restart is visible only as a later rise of `frame_avail_o`. The bench drives the carrier high across a frame close and counts cycles exactly from the carrier's fall. Random frames add random carrier pulses during the gap, and the checker confirms that every rise comes after a full run of carrier-low cycles. A second hard case is the short strobe glitch in the middle of a byte. The bench pulses the strobe high for one cycle fewer than the debounce count and confirms the byte on the pins stays put.

// File: rtl/frmrd_pkg.sv
package frmrd_pkg;
    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_GAP  = 2'd1,
        ST_SEND = 2'd2
    } rd_state_e;
endpackage

// File: rtl/frmrd_strobe_deb.sv
// Two-flop synchronizer followed by a hold-count debouncer for an
// active-low strobe. rise_o pulses for one cycle when the accepted level
// goes high.
module frmrd_strobe_deb #(
    parameter int DEB_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n_i,
    output logic rise_o
);
    localparam int CW = $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          lvl;
        logic [CW-1:0] cnt;
        logic          rise;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = strobe_n_i;
        st_d.s2   = st_q.s1;
        st_d.rise = 1'b0;
        if (st_q.s2 != st_q.lvl) begin
            if (st_q.cnt == CW'(DEB_CYC - 1)) begin
                st_d.lvl  = st_q.s2;
                st_d.cnt  = '0;
                st_d.rise = st_q.s2;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1   <= 1'b1;
            st_q.s2   <= 1'b1;
            st_q.lvl  <= 1'b1;
            st_q.cnt  <= '0;
            st_q.rise <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.rise;
endmodule

// File: rtl/frmrd_buf.sv
// Single-frame byte store: one synchronous write port and one
// combinational read port.
module frmrd_buf #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/frmrd_ctrl.sv
// Frame sequencer: fill, inter-frame gap, strobe-paced readout.
module frmrd_ctrl
    import frmrd_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int GAP_CYC = 24,
    parameter int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid_i,
    input  logic          wr_last_i,
    input  logic          carrier_i,
    input  logic          rise_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [AW-1:0] raddr_o,
    input  logic [7:0]    rdata_i,
    output logic          wr_ready_o,
    output logic          avail_o,
    output logic [7:0]    byte_o
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH + 2);
    localparam int GW = $clog2(GAP_CYC + 1);

    typedef struct packed {
        rd_state_e     state;
        logic [PW-1:0] fill;
        logic [GW-1:0] gap;
        logic [IW-1:0] idx;
    } ctl_t;

    ctl_t st_d, st_q;
    logic [15:0] len16;

    always_comb begin
        st_d = st_q;
        we_o = 1'b0;
        unique case (st_q.state)
            ST_FILL: begin
                if (wr_valid_i && (st_q.fill < PW'(DEPTH))) begin
                    we_o      = 1'b1;
                    st_d.fill = st_q.fill + PW'(1);
                end
                if (wr_last_i) begin
                    st_d.state = ST_GAP;
                    st_d.gap   = '0;
                end
            end
            ST_GAP: begin
                if (carrier_i) begin
                    st_d.gap = '0;
                end else if (st_q.gap == GW'(GAP_CYC - 1)) begin
                    st_d.state = ST_SEND;
                    st_d.idx   = '0;
                end else begin
                    st_d.gap = st_q.gap + GW'(1);
                end
            end
            ST_SEND: begin
                if (rise_i) begin
                    if (st_q.idx == (IW'(st_q.fill) + IW'(1))) begin
                        st_d.state = ST_FILL;
                        st_d.fill  = '0;
                    end else begin
                        st_d.idx = st_q.idx + IW'(1);
                    end
                end
            end
            default: st_d.state = ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_FILL;
            st_q.fill  <= '0;
            st_q.gap   <= '0;
            st_q.idx   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr_o    = AW'(st_q.fill);
    assign raddr_o    = AW'(st_q.idx) - AW'(2);
    assign len16      = 16'(st_q.fill);
    assign wr_ready_o = (st_q.state == ST_FILL);
    assign avail_o    = (st_q.state == ST_SEND);

    always_comb begin
        if (st_q.idx == '0) begin
            byte_o = len16[15:8];
        end else if (st_q.idx == IW'(1)) begin
            byte_o = len16[7:0];
        end else begin
            byte_o = rdata_i;
        end
    end
endmodule

// File: rtl/frmrd_port.sv
module frmrd_port #(
    parameter int DEPTH   = 64,
    parameter int GAP_CYC = 24,
    parameter int DEB_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] wr_data_i,
    input  logic       wr_valid_i,
    input  logic       wr_last_i,
    output logic       wr_ready_o,
    input  logic       tx_carrier_i,
    input  logic       host_cs_n_i,
    input  logic       host_rd_n_i,
    output logic       frame_avail_o,
    output logic [7:0] pin_data_o,
    output logic       pin_oe_o
);
    localparam int AW = $clog2(DEPTH);

    logic          strobe_rise;
    logic          buf_we;
    logic [AW-1:0] buf_waddr;
    logic [AW-1:0] buf_raddr;
    logic [7:0]    buf_rdata;

    frmrd_strobe_deb #(.DEB_CYC(DEB_CYC)) i_deb (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n_i (host_rd_n_i),
        .rise_o     (strobe_rise)
    );

    frmrd_buf #(.DEPTH(DEPTH), .AW(AW)) i_buf (
        .clk     (clk),
        .we_i    (buf_we),
        .waddr_i (buf_waddr),
        .wdata_i (wr_data_i),
        .raddr_i (buf_raddr),
        .rdata_o (buf_rdata)
    );

    frmrd_ctrl #(.DEPTH(DEPTH), .GAP_CYC(GAP_CYC), .AW(AW)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid_i),
        .wr_last_i  (wr_last_i),
        .carrier_i  (tx_carrier_i),
        .rise_i     (strobe_rise),
        .we_o       (buf_we),
        .waddr_o    (buf_waddr),
        .raddr_o    (buf_raddr),
        .rdata_i    (buf_rdata),
        .wr_ready_o (wr_ready_o),
        .avail_o    (frame_avail_o),
        .byte_o     (pin_data_o)
    );

    // Pad drivers follow the host pins directly so they turn on within
    // the strobe-low window.
    assign pin_oe_o = ~host_cs_n_i & ~host_rd_n_i;
endmodule

// File: rtl/frmrd_chk.sv
module frmrd_chk #(
    parameter int GAP_CYC = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_carrier_i,
    input logic       wr_ready_o,
    input logic       frame_avail_o,
    input logic [7:0] pin_data_o,
    input logic       rise
);
    // Run length of carrier-low cycles while a closed frame waits.
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (tx_carrier_i || wr_ready_o || frame_avail_o) begin
            run_q <= '0;
        end else if (run_q < 32'(GAP_CYC)) begin
            run_q <= run_q + 32'd1;
        end
    end

    AST_GAP_MET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_avail_o) |-> ($past(run_q) >= 32'(GAP_CYC - 1))); // R1

    AST_NO_CARRIER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_avail_o) |-> !$past(tx_carrier_i)); // R2

    AST_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_avail_o && $past(frame_avail_o) && !$stable(pin_data_o)) |-> $past(rise)); // R3

    AST_DROP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_avail_o) |-> $past(rise)); // R5
endmodule

bind frmrd_port frmrd_chk #(.GAP_CYC(GAP_CYC)) i_frmrd_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_carrier_i  (tx_carrier_i),
    .wr_ready_o    (wr_ready_o),
    .frame_avail_o (frame_avail_o),
    .pin_data_o    (pin_data_o),
    .rise          (strobe_rise)
);

// File: tb/test_frmrd_port.sv
module test_frmrd_port;
    localparam int DEPTH = 64;
    localparam int GAP   = 24;
    localparam int DEB   = 3;
    localparam int HOLD  = DEB + 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] wr_data;
    logic       wr_valid, wr_last, wr_ready;
    logic       carrier, cs_n, rd_n;
    logic       avail;
    logic [7:0] pdata;
    logic       poe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_b [128];
    int exp_len;

    always #4 clk = ~clk;

    frmrd_port #(.DEPTH(DEPTH), .GAP_CYC(GAP), .DEB_CYC(DEB)) i_frmrd_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_data_i     (wr_data),
        .wr_valid_i    (wr_valid),
        .wr_last_i     (wr_last),
        .wr_ready_o    (wr_ready),
        .tx_carrier_i  (carrier),
        .host_cs_n_i   (cs_n),
        .host_rd_n_i   (rd_n),
        .frame_avail_o (avail),
        .pin_data_o    (pdata),
        .pin_oe_o      (poe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] exp_at(input int k);
        if (k == 0) return 8'(exp_len >> 8);
        if (k == 1) return 8'(exp_len & 255);
        return exp_b[k-2];
    endfunction

    // Writes n random bytes; last_on_byte puts the end marker on the last
    // byte, otherwise a separate marker with valid low closes the frame.
    task automatic wr_frame(input int n, input bit last_on_byte);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_data  = 8'($urandom);
            wr_valid = 1'b1;
            wr_last  = last_on_byte && (i == n - 1);
            if (i < 128) exp_b[i] = wr_data;
            @(posedge clk);
        end
        if (n == 0 || !last_on_byte) begin
            @(negedge clk);
            wr_valid = 1'b0;
            wr_last  = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last  = 1'b0;
        exp_len  = (n > DEPTH) ? DEPTH : n;
    endtask

    task automatic rd_byte(output logic [7:0] b, output logic oe);
        @(negedge clk);
        cs_n = 1'b0;
        rd_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        b  = pdata;
        oe = poe;
        rd_n = 1'b1;
        repeat (HOLD) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic wait_avail();
        for (int i = 0; i < 3000 && !avail; i++) @(negedge clk);
        chk(avail == 1'b1, "R1 avail eventually", int'(avail), 1);
    endtask

    task automatic read_check(input string tag);
        logic [7:0] b;
        logic oe;
        for (int k = 0; k < exp_len + 2; k++) begin
            chk(avail == 1'b1, {"R3 avail during ", tag}, int'(avail), 1);
            rd_byte(b, oe);
            chk(b == exp_at(k), {"R4 byte ", tag}, int'(b), int'(exp_at(k)));
            chk(oe == 1'b1, "R6 oe while reading", int'(oe), 1);
        end
        chk(avail == 1'b0, {"R5 drop after last ", tag}, int'(avail), 0);
        chk(wr_ready == 1'b1, {"R8 ready after drop ", tag}, int'(wr_ready), 1);
    endtask

    task automatic gap_exact(input string tag);
        repeat (GAP - 1) @(negedge clk);
        chk(avail == 1'b0, {"R1 early ", tag}, int'(avail), 0);
        @(negedge clk);
        chk(avail == 1'b1, {"R1 on time ", tag}, int'(avail), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic oe;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        rst_n = 1'b0; wr_data = '0; wr_valid = 0; wr_last = 0;
        carrier = 0; cs_n = 1; rd_n = 1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(avail == 1'b0, "R10 avail after reset", int'(avail), 0);
        chk(wr_ready == 1'b1, "R10 ready after reset", int'(wr_ready), 1);

        // R6 output enable truth table, no clock needed
        cs_n = 1; rd_n = 0; #1;
        chk(poe == 1'b0, "R6 cs high", int'(poe), 0);
        cs_n = 0; rd_n = 1; #1;
        chk(poe == 1'b0, "R6 rd high", int'(poe), 0);
        cs_n = 0; rd_n = 0; #1;
        chk(poe == 1'b1, "R6 both low", int'(poe), 1);
        cs_n = 1; rd_n = 1; #1;
        chk(poe == 1'b0, "R6 both high", int'(poe), 0);
        repeat (HOLD) @(negedge clk);

        // R1 exact gap, short frame with end marker on the byte
        wr_frame(5, 1'b1);
        gap_exact("f5");
        read_check("f5");

        // R5 + R9 zero-length frame closed by a bare end marker
        wr_frame(0, 1'b0);
        gap_exact("f0");
        read_check("f0");

        // R9 separate end marker after bytes
        wr_frame(3, 1'b0);
        wait_avail();
        read_check("f3 marker");

        // R2 carrier held high across close, then exact count from its fall
        @(negedge clk);
        carrier = 1'b1;
        wr_frame(4, 1'b1);
        repeat (3 * GAP) @(negedge clk);
        chk(avail == 1'b0, "R2 held off by carrier", int'(avail), 0);
        carrier = 1'b0;
        gap_exact("after carrier");
        read_check("R2 frame");

        // R2 carrier pulse mid-gap restarts the count
        wr_frame(2, 1'b1);
        repeat (GAP / 2) @(negedge clk);
        carrier = 1'b1;
        @(negedge clk);
        carrier = 1'b0;
        gap_exact("restart");
        read_check("restart frame");

        // R7 short strobe glitch in mid-byte, then R8 writes while busy
        wr_frame(6, 1'b1);
        wait_avail();
        chk(wr_ready == 1'b0, "R8 not ready while held", int'(wr_ready), 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            wr_data = 8'hEE; wr_valid = 1'b1; wr_last = (i == 4);
        end
        @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0;
        cs_n = 1'b0; rd_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        rd_n = 1'b1;
        repeat (DEB - 1) @(negedge clk);
        rd_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        chk(pdata == exp_at(0), "R7 glitch ignored", int'(pdata), int'(exp_at(0)));
        rd_n = 1'b1;
        repeat (HOLD) @(negedge clk);
        cs_n = 1'b1;
        chk(pdata == exp_at(1), "R3 step after real edge", int'(pdata), int'(exp_at(1)));
        for (int k = 1; k < exp_len + 2; k++) begin
            rd_byte(b, oe);
            chk(b == exp_at(k), "R8 held frame unchanged", int'(b), int'(exp_at(k)));
        end
        chk(avail == 1'b0, "R5 drop glitch frame", int'(avail), 0);

        // R9 overflow: bytes beyond DEPTH dropped
        wr_frame(DEPTH + 6, 1'b1);
        wait_avail();
        read_check("R9 overflow");

        // Random frames with random carrier pulses during the gap
        for (int f = 0; f < 8; f++) begin
            int n;
            n = 1 + int'($urandom % 24);
            wr_frame(n, 1'($urandom % 2));
            for (int i = 0; i < 40 && !avail; i++) begin
                carrier = (($urandom % 8) == 0);
                @(negedge clk);
            end
            carrier = 1'b0;
            wait_avail();
            read_check("random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule